// File: doc/BRIEF.md
# Streaming Hamming Check-Code Generator for Flash Pages

This block computes a three-byte Hamming check code over a stream of data bytes, one byte per clock when the valid strobe is high. Every 256 accepted bytes form one chunk. The block keeps two sets of parity. Column parities are built from the bit positions inside each byte. Line parities are built from the position of every byte whose bits have odd parity.

When the last byte of a chunk is taken, the block registers the finished code and raises a done strobe for one cycle. The accumulators then return to zero, so a page that spans several chunks is sent as one continuous stream. A start input discards a partial chunk and begins a new one.

The finished code is inverted, and its two lowest bits are forced to one. A later correction stage compares this code with the code stored in the spare area of the page.

Top module: `ham_ecc_gen`

## Requirements
- R1: `ecc_valid` is high for exactly one cycle: the cycle after the clock edge that takes the 256th accepted byte of a chunk. It is low at every other time.
- R2: Column parities sit in `ecc[7:2]`, each inverted. Take a column term as the XOR, across the chunk, of a group of data bits:
  - bit 2 uses data bits {0,2,4,6}
  - bit 3 uses {1,3,5,7}
  - bit 4 uses {0,1,4,5}
  - bit 5 uses {2,3,6,7}
  - bit 6 uses {0,1,2,3}
  - bit 7 uses {4,5,6,7}
- R3: Line parities change only for accepted bytes whose eight bits XOR to 1. For such a byte at chunk position i, and for k from 0 to 3, index bit k toggles bit 2k of the byte-2 term (`ecc[23:16]`) when that index bit is 0. It toggles bit 2k+1 when that index bit is 1. Bytes with even parity leave the line terms unchanged.
- R4: Index bits 4 to 7 work the same way on the byte-1 term (`ecc[15:8]`). Index bit 4+k toggles bit 2k when it is 0, and bit 2k+1 when it is 1.
- R5: The output code is the bitwise inverse of the accumulated terms, with `ecc[1:0]` forced to 2'b11. Byte 0 is `ecc[7:0]`, byte 1 is `ecc[15:8]` and byte 2 is `ecc[23:16]`.
- R6: A cycle with `in_valid` low neither advances the byte position nor changes any parity. Such cycles may fall anywhere inside a chunk.
- R7: `start` clears the byte position and all parities. A byte presented in the same cycle as `start` is discarded.
- R8: After a chunk completes, the next accepted byte is position 0 of a new chunk, and accumulation starts from zero. Chunks may follow each other with no idle cycle.
- R9: Reset sets `ecc` to 0 and `ecc_valid` to 0. `ecc` keeps its last value until the next chunk completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Abandon the current chunk and clear all state |
| in_valid | input | 1 | `in_byte` is valid this cycle |
| in_byte | input | 8 | Data byte |
| ecc | output | 24 | Finished check code; byte 0 is in bits 7:0 |
| ecc_valid | output | 1 | One-cycle pulse when `ecc` is updated |

## Verification
The code and its strobe are both registered. They are due one cycle after the edge that takes a chunk's last byte, and in that cycle only. The bench drives inputs on the falling edge and checks `ecc_valid` and `ecc` on every following falling edge.

Each check compares the code against a bench model that updates as each byte is driven. The strobe must be low on every other check. `ecc` must keep its previous value on those cycles.

Idle gaps, `start` pulses and back-to-back chunks move the expected completion cycle. The bench tracks this by counting accepted bytes, not cycles.

// File: rtl/ham_ecc_pkg.sv
package ham_ecc_pkg;
  localparam int CHUNK_BYTES = 256;
  localparam int BYTE_W      = 8;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int COL_W       = 2 * $clog2(BYTE_W);
  localparam int LINE_W      = 2 * IDX_W;
  localparam int CODE_W      = COL_W + 2 + LINE_W;

  // Term j selects the data bits whose bit-position bit (j/2) equals (j%2).
  function automatic logic [COL_W-1:0] col_terms(input logic [BYTE_W-1:0] b);
    logic [COL_W-1:0] t;
    t = '0;
    for (int j = 0; j < COL_W; j++) begin
      for (int p = 0; p < BYTE_W; p++) begin
        if (((p >> (j / 2)) & 1) == (j % 2)) t[j] = t[j] ^ b[p];
      end
    end
    return t;
  endfunction
endpackage

// File: rtl/ham_chunk_ctr.sv
module ham_chunk_ctr
  import ham_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             in_valid,
  output logic [IDX_W-1:0] idx,
  output logic             take,
  output logic             last
);
  logic [IDX_W-1:0] idx_q;

  assign take = in_valid & ~start;
  assign last = (idx_q == IDX_W'(CHUNK_BYTES - 1));
  assign idx  = idx_q;

  // Wraps naturally after the final position of a chunk.
  always_ff @(posedge clk) begin
    if (rst || start) idx_q <= '0;
    else if (take)    idx_q <= idx_q + 1'b1;
  end

  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    start |=> (idx == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !start) |=> $stable(idx)); // R6
endmodule

// File: rtl/ham_col_acc.sv
module ham_col_acc
  import ham_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [BYTE_W-1:0] din,
  output logic [COL_W-1:0]  sum
);
  logic [COL_W-1:0] col_q;

  assign sum = take ? (col_q ^ col_terms(din)) : col_q;

  always_ff @(posedge clk) begin
    if (rst || clr) col_q <= '0;
    else            col_q <= sum;
  end

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (col_q == '0)); // R8
endmodule

// File: rtl/ham_line_acc.sv
module ham_line_acc
  import ham_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] din,
  output logic [LINE_W-1:0] sum
);
  logic [LINE_W-1:0] lp_q;
  logic [LINE_W-1:0] flip;
  logic              odd;

  assign odd = ^din;

  // Each index bit owns a true/complement pair of line terms.
  for (genvar k = 0; k < IDX_W; k++) begin : g_pair
    assign flip[2*k]   = take & odd & ~idx[k];
    assign flip[2*k+1] = take & odd &  idx[k];
  end

  assign sum = lp_q ^ flip;

  always_ff @(posedge clk) begin
    if (rst || clr) lp_q <= '0;
    else            lp_q <= sum;
  end

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!take && !clr) |=> $stable(lp_q)); // R6
  AST_EVEN_NO_LINE: assert property (@(posedge clk) disable iff (rst)
    (take && !(^din) && !clr) |=> $stable(lp_q)); // R3
endmodule

// File: rtl/ham_ecc_gen.sv
module ham_ecc_gen
  import ham_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic [CODE_W-1:0] ecc,
  output logic              ecc_valid
);
  logic [IDX_W-1:0]  idx;
  logic              take;
  logic              last;
  logic              clr;
  logic              done;
  logic [COL_W-1:0]  col_sum;
  logic [LINE_W-1:0] line_sum;
  logic [CODE_W-1:0] ecc_q;
  logic              vld_q;

  assign done = take & last;
  assign clr  = start | done;

  ham_chunk_ctr u_ctr (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .idx(idx), .take(take), .last(last)
  );

  ham_col_acc u_col (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .din(in_byte), .sum(col_sum)
  );

  ham_line_acc u_line (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .idx(idx), .din(in_byte),
    .sum(line_sum)
  );

  // Byte 2 carries the low-index pairs, byte 1 the high-index pairs.
  always_ff @(posedge clk) begin
    if (rst) begin
      ecc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= done;
      if (done)
        ecc_q <= {~line_sum[LINE_W/2-1:0], ~line_sum[LINE_W-1:LINE_W/2],
                  ~col_sum, 2'b11};
    end
  end

  assign ecc       = ecc_q;
  assign ecc_valid = vld_q;

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    ecc_valid |=> !ecc_valid); // R1
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ecc_valid |-> $past(in_valid && !start && idx == IDX_W'(CHUNK_BYTES - 1))); // R1
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    ecc_valid |-> (ecc[1:0] == 2'b11)); // R5
  AST_HOLD_CODE: assert property (@(posedge clk) disable iff (rst)
    !ecc_valid |-> $stable(ecc)); // R9
endmodule

// File: tb/ham_ecc_gen_test.sv
`timescale 1ns/1ps
module ham_ecc_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic [23:0] ecc;
  logic        ecc_valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ham_ecc_gen uut (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .ecc(ecc), .ecc_valid(ecc_valid)
  );

  // mode: 0 all val, 1 val at pos only, 2 i*val+pos+chunk, 3 i^val^chunk
  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  val;
    logic [7:0]  pos;
    logic        gap;
    logic [1:0]  nchunk;
    logic [3:0]  tag;
    logic [23:0] hexp;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 8'h00, 8'd0,   1'b0, 2'd1, 4'd2, 24'hFFFFFF},
    '{2'd0, 8'hFF, 8'd0,   1'b0, 2'd1, 4'd3, 24'hFFFFFF},
    '{2'd1, 8'h01, 8'd0,   1'b0, 2'd1, 4'd3, 24'hAAAAAB},
    '{2'd1, 8'h80, 8'd255, 1'b0, 2'd1, 4'd4, 24'h555557},
    '{2'd1, 8'h03, 8'd0,   1'b0, 2'd1, 4'd3, 24'hFFFFF3},
    '{2'd1, 8'h10, 8'h5A,  1'b0, 2'd1, 4'd4, 24'h66996B},
    '{2'd2, 8'd1,  8'd0,   1'b0, 2'd2, 4'd5, 24'h000000},
    '{2'd3, 8'h3C, 8'd0,   1'b1, 2'd1, 4'd6, 24'h000000},
    '{2'd2, 8'd37, 8'd11,  1'b0, 2'd3, 4'd8, 24'h000000}
  };

  // Bench reference state
  logic [5:0]  m_col;
  logic [15:0] m_lp;
  int          m_cnt;
  logic        pend;
  logic [23:0] pend_exp;
  logic [23:0] pend_hexp;
  logic [23:0] last_exp;
  string       cur_tag;

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] pat(input logic [1:0] mode, input logic [7:0] val,
                                     input logic [7:0] pos, input int c, input int i);
    case (mode)
      2'd0: return val;
      2'd1: return (i == int'(pos)) ? val : 8'h00;
      2'd2: return 8'(i * int'(val) + int'(pos) + c);
      default: return 8'(i) ^ val ^ 8'(c);
    endcase
  endfunction

  task automatic mdl_clear();
    m_col = '0; m_lp = '0; m_cnt = 0;
  endtask

  task automatic mdl_add(input logic [7:0] b);
    logic [7:0] ix;
    ix = 8'(m_cnt);
    m_col[0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
    m_col[1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
    m_col[2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
    m_col[3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
    m_col[4] ^= b[0] ^ b[1] ^ b[2] ^ b[3];
    m_col[5] ^= b[4] ^ b[5] ^ b[6] ^ b[7];
    if (^b) begin
      for (int k = 0; k < 8; k++) m_lp[2*k + int'(ix[k])] ^= 1'b1;
    end
    m_cnt++;
    if (m_cnt == 256) begin
      pend = 1'b1;
      pend_exp = {~m_lp[7:0], ~m_lp[15:8], ~m_col, 2'b11};
      mdl_clear();
    end
  endtask

  // One cycle; checks strobe and code on the falling edge.
  task automatic tick();
    @(negedge clk);
    n_chk++;
    if (pend) begin
      if (ecc_valid !== 1'b1) begin
        n_fail++;
        $display("FAIL R1: ecc_valid=%0b expected 1", ecc_valid);
      end
      n_chk++;
      if (ecc !== pend_exp) begin
        n_fail++;
        $display("FAIL %s: ecc=%06h expected %06h", cur_tag, ecc, pend_exp);
      end
      if (pend_hexp != 24'h0) begin
        n_chk++;
        if (ecc !== pend_hexp) begin
          n_fail++;
          $display("FAIL %s R5: ecc=%06h expected %06h", cur_tag, ecc, pend_hexp);
        end
      end
      last_exp = pend_exp;
      pend = 1'b0;
    end else begin
      if (ecc_valid !== 1'b0) begin
        n_fail++;
        $display("FAIL R1: ecc_valid=%0b expected 0", ecc_valid);
      end
      n_chk++;
      if (ecc !== last_exp) begin
        n_fail++;
        $display("FAIL R9: ecc=%06h expected %06h", ecc, last_exp);
      end
    end
  endtask

  task automatic feed(input logic [1:0] mode, input logic [7:0] val, input logic [7:0] pos,
                      input logic gap, input int nbytes, input logic [23:0] hexp);
    logic [7:0] b;
    for (int j = 0; j < nbytes; j++) begin
      tick();
      b = pat(mode, val, pos, j / 256, j % 256);
      in_valid = 1'b1;
      in_byte  = b;
      pend_hexp = hexp;
      mdl_add(b);
      if (gap && (j % 7 == 3)) begin
        tick();
        in_valid = 1'b0;
        in_byte  = 8'h01;
      end
    end
    tick();
    in_valid = 1'b0;
    in_byte  = 8'h01;
    tick();
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pend = 1'b0; pend_exp = '0; pend_hexp = '0; last_exp = '0;
    cur_tag = "R9";
    mdl_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state (tick checks ecc==0 and ecc_valid==0)
    tick();
    tick();

    // Table of patterns with hand-derived or modelled expected codes
    for (int v = 0; v < 9; v++) begin
      cur_tag = tag_name(VECS[v].tag);
      feed(VECS[v].mode, VECS[v].val, VECS[v].pos, VECS[v].gap,
           256 * int'(VECS[v].nchunk), VECS[v].hexp);
    end

    // R7: start abandons a partial chunk
    cur_tag = "R7";
    feed(2'd2, 8'd5, 8'd3, 1'b0, 100, 24'h0);
    start = 1'b1;
    mdl_clear();
    tick();
    start = 1'b0;
    feed(2'd1, 8'h01, 8'd0, 1'b0, 256, 24'hAAAAAB);

    // R7: byte given together with start is discarded
    feed(2'd3, 8'h77, 8'd0, 1'b0, 40, 24'h0);
    tick();
    start = 1'b1;
    in_valid = 1'b1;
    in_byte = 8'h01;
    mdl_clear();
    tick();
    start = 1'b0;
    in_valid = 1'b0;
    feed(2'd0, 8'h00, 8'd0, 1'b0, 256, 24'hFFFFFF);

    // R8: back-to-back chunks with gaps in the second page
    cur_tag = "R8";
    feed(2'd3, 8'hA5, 8'd0, 1'b1, 512, 24'h0);

    // R9: idle hold
    repeat (5) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule